// File: doc/BRIEF.md
# Half-Bridge Gate Handshake Sequencer

This block sits between a PWM-style command and the gate current sources of one half-bridge. For each side (high and low) it raises exactly one of four drive enables: strong source, hold source, strong pulldown or weak pulldown. A side only starts to turn on once the comparator on the opposite gate reports that gate below threshold. The dead time is therefore set by the power devices themselves and not by a fixed delay. While that wait lasts, the opposite gate is pulled down hard.

Once the handshake clears, the commanded gate gets strong source current for a programmable number of cycles. At the end of that window the block checks the gate's own comparator. If the gate has risen, the side drops to a small hold current and the opposite side relaxes to weak pulldown. If the gate has not risen, the block latches a fault and parks both gates on weak pulldown until software clears it. A turn-off command gives the conducting gate a strong sink for the same window and then leaves both gates on weak pulldown. A handshake that never completes also raises the fault.

The command is a level. Changes that arrive during a transition do not abort it. When the sequence reaches a stable point, the block acts on whatever the command is at that moment.

Top module: `hbs_gate_seq`

## Requirements
- R1: During and after reset every side drives only its weak pulldown and the fault flag is low.
- R2: Command encoding on cmd_i: 2'b10 turns the high side on, 2'b01 turns the low side on, and both 2'b00 and 2'b11 mean both sides off.
- R3: The commanded side's strong source starts in the cycle after a clock edge at which the opposite gate comparator was sampled low. Until then the commanded side stays on weak pulldown.
- R4: The strong source lasts exactly the tDRIVE count of cycles, sampled from tdrive_i at the edge that starts the transition. A count of 0 acts as 1, and later changes of tdrive_i do not alter a running window.
- R5: At the end of the window, if the commanded gate comparator is high, that side switches to its hold source and the opposite side switches to weak pulldown.
- R6: If the commanded gate comparator is low at the end of the window, fault_o rises and both sides drive only weak pulldown.
- R7: Throughout the handshake wait and the strong-source window, the opposite side drives its strong pulldown.
- R8: On an off command from a held side, that side drives its strong pulldown for tDRIVE cycles and then both sides drive weak pulldown.
- R9: If the opposite gate comparator stays high for HS_TMO consecutive cycles of handshake wait, fault_o rises and both sides drive weak pulldown.
- R10: The fault stays latched, and commands are ignored, until fault_clr_i is sampled high. The block then idles with both sides on weak pulldown for one cycle and acts on the current command.
- R11: Each side always drives exactly one of its four enables, and the two strong sources are never high in the same cycle.
- R12: A command change during a transition is not acted upon until the transition ends. Only the command level present at that point is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | Bridge command (see R2) |
| hi_gate_up_i | input | 1 | High-side gate above threshold |
| lo_gate_up_i | input | 1 | Low-side gate above threshold |
| tdrive_i | input | TW | Strong-drive window length in cycles |
| fault_clr_i | input | 1 | Clears a latched fault |
| hi_src_strong_o | output | 1 | High-side strong source enable |
| hi_src_hold_o | output | 1 | High-side hold source enable |
| hi_snk_strong_o | output | 1 | High-side strong pulldown enable |
| hi_snk_weak_o | output | 1 | High-side weak pulldown enable |
| lo_src_strong_o | output | 1 | Low-side strong source enable |
| lo_src_hold_o | output | 1 | Low-side hold source enable |
| lo_snk_strong_o | output | 1 | Low-side strong pulldown enable |
| lo_snk_weak_o | output | 1 | Low-side weak pulldown enable |
| fault_o | output | 1 | Latched gate or handshake fault |

## Verification
All outputs are decoded from registered state, so every input sampled at a rising edge shows up on the outputs right after that same edge. A change of command or comparator therefore becomes visible one cycle after it is applied. The window and the timeout are counted from the edge that entered the phase: a window of N cycles shows N cycles of strong drive, and the next edge moves on. The bench drives inputs on falling edges and queues the expected output word for the following rising edge. A monitor compares that word a quarter period after the rising edge, so each expectation lands exactly in its due cycle.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DRIVE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_SINK  = 3'd4,
    ST_FAULT = 3'd5
  } hbs_state_e;

  localparam logic [1:0] CMD_LO_ON = 2'b01;
  localparam logic [1:0] CMD_HI_ON = 2'b10;

  localparam int SIDE_LO = 0;
  localparam int SIDE_HI = 1;
endpackage

// File: rtl/hbs_timer.sv
module hbs_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!done)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl
  import hbs_pkg::*;
#(
  parameter int TW     = 8,
  parameter int HS_TMO = 64,
  parameter int CW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd,
  input  logic          hi_up,
  input  logic          lo_up,
  input  logic [TW-1:0] tdrive,
  input  logic          clear,
  input  logic          done,
  output logic          restart,
  output logic [CW-1:0] limit,
  output hbs_state_e    state_q,
  output logic          side_q
);
  hbs_state_e    state_d;
  logic          side_d;
  logic [CW-1:0] tdrv_q;
  logic          want_hi, want_lo, want_on, tgt_up, opp_up;

  assign want_hi = (cmd == CMD_HI_ON);
  assign want_lo = (cmd == CMD_LO_ON);
  assign want_on = want_hi | want_lo;
  assign tgt_up  = side_q ? hi_up : lo_up;
  assign opp_up  = side_q ? lo_up : hi_up;

  always_comb begin
    state_d = state_q;
    side_d  = side_q;
    unique case (state_q)
      ST_IDLE: if (want_on) begin
        side_d  = want_hi;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!opp_up)   state_d = ST_DRIVE;
        else if (done) state_d = ST_FAULT;
      end
      ST_DRIVE: if (done) state_d = tgt_up ? ST_HOLD : ST_FAULT;
      ST_HOLD: begin
        if (!want_on) state_d = ST_SINK;
        else if (want_hi != side_q) begin
          side_d  = want_hi;
          state_d = ST_WAIT;
        end
      end
      ST_SINK:  if (done) state_d = ST_IDLE;
      ST_FAULT: if (clear) state_d = ST_IDLE;
      default:  state_d = ST_FAULT;
    endcase
  end

  assign restart = (state_d != state_q);
  assign limit   = (state_q == ST_WAIT) ? CW'(HS_TMO) : tdrv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      side_q  <= 1'b0;
      tdrv_q  <= CW'(1);
    end else begin
      state_q <= state_d;
      side_q  <= side_d;
      if (restart && (state_d == ST_WAIT || state_d == ST_SINK))
        tdrv_q <= (tdrive == '0) ? CW'(1) : CW'(tdrive);
    end
  end
endmodule

// File: rtl/hbs_drive_map.sv
module hbs_drive_map
  import hbs_pkg::*;
(
  input  hbs_state_e state,
  input  logic       side,
  output logic [1:0] src_strong,
  output logic [1:0] src_hold,
  output logic [1:0] snk_strong,
  output logic [1:0] snk_weak,
  output logic       fault
);
  assign fault = (state == ST_FAULT);

  for (genvar g = 0; g < 2; g++) begin : g_side
    logic is_tgt;
    assign is_tgt        = (side == g[0]);
    assign src_strong[g] = (state == ST_DRIVE) && is_tgt;
    assign src_hold[g]   = (state == ST_HOLD) && is_tgt;
    assign snk_strong[g] = ((state == ST_WAIT || state == ST_DRIVE) && !is_tgt)
                         || ((state == ST_SINK) && is_tgt);
    assign snk_weak[g]   = !(src_strong[g] | src_hold[g] | snk_strong[g]);
  end
endmodule

// File: rtl/hbs_gate_seq.sv
module hbs_gate_seq
  import hbs_pkg::*;
#(
  parameter int TW     = 8,
  parameter int HS_TMO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cmd_i,
  input  logic          hi_gate_up_i,
  input  logic          lo_gate_up_i,
  input  logic [TW-1:0] tdrive_i,
  input  logic          fault_clr_i,
  output logic          hi_src_strong_o,
  output logic          hi_src_hold_o,
  output logic          hi_snk_strong_o,
  output logic          hi_snk_weak_o,
  output logic          lo_src_strong_o,
  output logic          lo_src_hold_o,
  output logic          lo_snk_strong_o,
  output logic          lo_snk_weak_o,
  output logic          fault_o
);
  localparam int HW = $clog2(HS_TMO + 1);
  localparam int CW = (TW > HW) ? TW : HW;

  hbs_state_e    state_q;
  logic          side_q, restart, done;
  logic [CW-1:0] limit;
  logic [1:0]    src_strong, src_hold, snk_strong, snk_weak;

  hbs_ctrl #(.TW(TW), .HS_TMO(HS_TMO), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_i),
    .hi_up(hi_gate_up_i), .lo_up(lo_gate_up_i),
    .tdrive(tdrive_i), .clear(fault_clr_i), .done(done),
    .restart(restart), .limit(limit), .state_q(state_q), .side_q(side_q)
  );

  hbs_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .limit(limit), .done(done)
  );

  hbs_drive_map u_map (
    .state(state_q), .side(side_q),
    .src_strong(src_strong), .src_hold(src_hold),
    .snk_strong(snk_strong), .snk_weak(snk_weak), .fault(fault_o)
  );

  assign hi_src_strong_o = src_strong[SIDE_HI];
  assign hi_src_hold_o   = src_hold[SIDE_HI];
  assign hi_snk_strong_o = snk_strong[SIDE_HI];
  assign hi_snk_weak_o   = snk_weak[SIDE_HI];
  assign lo_src_strong_o = src_strong[SIDE_LO];
  assign lo_src_hold_o   = src_hold[SIDE_LO];
  assign lo_snk_strong_o = snk_strong[SIDE_LO];
  assign lo_snk_weak_o   = snk_weak[SIDE_LO];
endmodule

// File: rtl/hbs_gate_seq_chk.sv
module hbs_gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic hi_gate_up_i,
  input logic lo_gate_up_i,
  input logic fault_clr_i,
  input logic hi_src_strong_o,
  input logic hi_src_hold_o,
  input logic hi_snk_strong_o,
  input logic hi_snk_weak_o,
  input logic lo_src_strong_o,
  input logic lo_src_hold_o,
  input logic lo_snk_strong_o,
  input logic lo_snk_weak_o,
  input logic fault_o
);
  AST_HI_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hi_src_strong_o, hi_src_hold_o, hi_snk_strong_o, hi_snk_weak_o}) == 1); // R11
  AST_LO_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lo_src_strong_o, lo_src_hold_o, lo_snk_strong_o, lo_snk_weak_o}) == 1); // R11
  AST_NO_DUAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_src_strong_o && lo_src_strong_o)); // R11
  AST_HI_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_src_strong_o) |-> !$past(lo_gate_up_i)); // R3
  AST_LO_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_src_strong_o) |-> !$past(hi_gate_up_i)); // R3
  AST_HI_HOLD_GATE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_src_hold_o) |-> $past(hi_gate_up_i)); // R5
  AST_FAULT_PARKS_WEAK: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (hi_snk_weak_o && lo_snk_weak_o)); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_clr_i) |=> fault_o); // R10
endmodule

bind hbs_gate_seq hbs_gate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .hi_gate_up_i(hi_gate_up_i), .lo_gate_up_i(lo_gate_up_i),
  .fault_clr_i(fault_clr_i),
  .hi_src_strong_o(hi_src_strong_o), .hi_src_hold_o(hi_src_hold_o),
  .hi_snk_strong_o(hi_snk_strong_o), .hi_snk_weak_o(hi_snk_weak_o),
  .lo_src_strong_o(lo_src_strong_o), .lo_src_hold_o(lo_src_hold_o),
  .lo_snk_strong_o(lo_snk_strong_o), .lo_snk_weak_o(lo_snk_weak_o),
  .fault_o(fault_o)
);

// File: tb/tb_hbs_gate_seq.sv
module tb_hbs_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TW  = 8;
  localparam int TMO = 8;

  // Expected word: {fault, hi strong src, hi hold, hi strong snk, hi weak, lo same four}
  localparam logic [8:0] WEAK    = 9'b0_0001_0001;
  localparam logic [8:0] HI_WAIT = 9'b0_0001_0010;
  localparam logic [8:0] HI_DRV  = 9'b0_1000_0010;
  localparam logic [8:0] HI_HOLD = 9'b0_0100_0001;
  localparam logic [8:0] HI_SINK = 9'b0_0010_0001;
  localparam logic [8:0] LO_WAIT = 9'b0_0010_0001;
  localparam logic [8:0] LO_DRV  = 9'b0_0010_1000;
  localparam logic [8:0] LO_HOLD = 9'b0_0001_0100;
  localparam logic [8:0] LO_SINK = 9'b0_0001_0010;
  localparam logic [8:0] FLT     = 9'b1_0001_0001;
  localparam logic [1:0] C_OFF = 2'b00, C_LO = 2'b01, C_HI = 2'b10, C_BOTH = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd = C_OFF;
  logic hi_up = 1'b0, lo_up = 1'b0, clr = 1'b0;
  logic [TW-1:0] tdrv = 8'd3;
  logic hss, hhs, hsk, hwk, lss, lhs, lsk, lwk, flt;
  logic [8:0] act;
  int vectors = 0, miscompares = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  hbs_gate_seq #(.TW(TW), .HS_TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd),
    .hi_gate_up_i(hi_up), .lo_gate_up_i(lo_up),
    .tdrive_i(tdrv), .fault_clr_i(clr),
    .hi_src_strong_o(hss), .hi_src_hold_o(hhs),
    .hi_snk_strong_o(hsk), .hi_snk_weak_o(hwk),
    .lo_src_strong_o(lss), .lo_src_hold_o(lhs),
    .lo_snk_strong_o(lsk), .lo_snk_weak_o(lwk),
    .fault_o(flt)
  );

  assign act = {flt, hss, hhs, hsk, hwk, lss, lhs, lsk, lwk};

  task automatic compare(input logic [8:0] e, input string t);
    vectors++;
    if (act !== e) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  // Driver: inputs on the falling edge, expectation due after the next rising edge
  task automatic step(input logic [1:0] c, input logic hu, input logic lu,
                      input logic cl, input logic [TW-1:0] td,
                      input logic [8:0] e, input string t);
    @(negedge clk);
    cmd = c; hi_up = hu; lo_up = lu; clr = cl; tdrv = td;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // Monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    miscompares++;
    vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare(WEAK, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    step(C_OFF, 0, 0, 0, 3, WEAK, "R1 idle after reset");
    step(C_OFF, 0, 0, 0, 3, WEAK, "R1 idle after reset");
    // High side on
    step(C_HI, 0, 0, 0, 3, HI_WAIT, "R2 high command enters handshake");
    step(C_HI, 0, 0, 0, 3, HI_DRV,  "R3 high strong source after low gate low");
    step(C_HI, 1, 0, 0, 3, HI_DRV,  "R4 window cycle 2");
    step(C_HI, 1, 0, 0, 3, HI_DRV,  "R7 low strong sink during window");
    step(C_HI, 1, 0, 0, 3, HI_HOLD, "R5 high hold after window");
    step(C_HI, 1, 0, 0, 3, HI_HOLD, "R5 hold steady");
    // Switch to low, high gate slow to fall
    step(C_LO, 1, 0, 0, 3, LO_WAIT, "R7 high strong sink on switch");
    step(C_LO, 1, 0, 0, 3, LO_WAIT, "R3 low held off while high gate up");
    step(C_LO, 1, 0, 0, 3, LO_WAIT, "R3 low held off while high gate up");
    step(C_LO, 0, 0, 0, 3, LO_DRV,  "R3 low strong source after release");
    step(C_LO, 0, 1, 0, 3, LO_DRV,  "R4 window cycle 2");
    step(C_LO, 0, 1, 0, 3, LO_DRV,  "R4 window cycle 3");
    step(C_LO, 0, 1, 0, 3, LO_HOLD, "R5 low hold after window");
    // Off with queued command changes
    step(C_OFF, 0, 1, 0, 3, LO_SINK, "R8 low strong sink on off");
    step(C_HI,  0, 0, 0, 3, LO_SINK, "R12 change ignored mid sink");
    step(C_LO,  0, 0, 0, 3, LO_SINK, "R12 change ignored mid sink");
    step(C_LO,  0, 0, 0, 3, WEAK,    "R8 both weak after sink");
    step(C_LO,  0, 0, 0, 3, LO_WAIT, "R12 latest command applied");
    step(C_LO,  0, 0, 0, 3, LO_DRV,  "R3 low drive");
    step(C_LO,  0, 1, 0, 3, LO_DRV,  "R4 window");
    step(C_LO,  0, 1, 0, 3, LO_DRV,  "R4 window");
    step(C_LO,  0, 1, 0, 3, LO_HOLD, "R5 low hold");
    // Stuck high gate
    step(C_HI, 0, 1, 0, 3, HI_WAIT, "R7 low strong sink on switch");
    step(C_HI, 0, 0, 0, 3, HI_DRV,  "R3 high drive");
    step(C_HI, 0, 0, 0, 3, HI_DRV,  "R4 window");
    step(C_HI, 0, 0, 0, 3, HI_DRV,  "R4 window");
    step(C_HI, 0, 0, 0, 3, FLT,     "R6 gate did not rise");
    step(C_HI, 1, 0, 0, 3, FLT,     "R10 fault latched");
    step(C_LO, 0, 0, 0, 3, FLT,     "R10 command ignored in fault");
    step(C_HI, 0, 0, 1, 3, WEAK,    "R10 clear returns to idle");
    step(C_HI, 0, 0, 0, 3, HI_WAIT, "R10 resumes current command");
    step(C_HI, 0, 0, 0, 3, HI_DRV,  "R3 high drive");
    step(C_HI, 1, 0, 0, 3, HI_DRV,  "R4 window");
    step(C_HI, 1, 0, 0, 3, HI_DRV,  "R4 window");
    step(C_HI, 1, 0, 0, 3, HI_HOLD, "R5 high hold");
    // Handshake timeout: high gate never falls
    for (int i = 0; i < TMO; i++)
      step(C_LO, 1, 0, 0, 3, LO_WAIT, "R9 waiting for high gate");
    step(C_LO,  1, 0, 0, 3, FLT,  "R9 handshake timeout");
    step(C_OFF, 1, 0, 1, 3, WEAK, "R10 clear");
    step(C_OFF, 0, 0, 0, 3, WEAK, "R2 off stays idle");
    // Zero window acts as one; 2'b11 is off
    step(C_HI, 0, 0, 0, 0, HI_WAIT, "R4 zero window start");
    step(C_HI, 1, 0, 0, 0, HI_DRV,  "R4 single strong cycle");
    step(C_HI, 1, 0, 0, 0, HI_HOLD, "R4 zero treated as one");
    step(C_BOTH, 1, 0, 0, 2, HI_SINK, "R2 both bits means off");
    step(C_BOTH, 0, 0, 0, 2, HI_SINK, "R8 sink window 2");
    step(C_BOTH, 0, 0, 0, 2, WEAK,    "R8 both weak after sink");
    step(C_BOTH, 0, 0, 0, 2, WEAK,    "R2 both bits stays off");
    // Window length latched at transition start
    step(C_HI, 0, 0, 0, 4, HI_WAIT, "R4 latch window of 4");
    step(C_HI, 0, 0, 0, 1, HI_DRV,  "R4 window 1 of 4");
    step(C_HI, 1, 0, 0, 1, HI_DRV,  "R4 window 2 of 4");
    step(C_HI, 1, 0, 0, 1, HI_DRV,  "R4 window 3 of 4");
    step(C_HI, 1, 0, 0, 1, HI_DRV,  "R4 window 4 of 4");
    step(C_HI, 1, 0, 0, 1, HI_HOLD, "R4 window not cut short");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule